// File: doc/BRIEF.md
# Serial Configuration Register Port

This block lets a host read and write a 48-bit configuration register over a clocked serial link. The lower 24 bits are the base register and the upper 24 bits are the extension. The host raises a select line and picks a direction. It then toggles an interface clock, which the block samples in its own system clock domain. The host must hold the direction input steady for the whole session.

On a write, one bit is taken MSB first on each rising edge of the interface clock. Nothing is stored until the select line falls. At that point the number of bits received is checked against the rules of the current mode, and the register is either updated or left as it was.

Two register bits set the behaviour:
- Bit 21 chooses between normal and extended length rules.
- Bit 18 chooses the length of an extended read.

A one-cycle status pulse reports a write that carried a substantial number of bits but still had to be dropped. On a read, the register is presented MSB first on the receive line. Each bit is valid at the interface clock rising edge that follows it.

Top module: `cfg_serial_access`

## Requirements
- R1: After reset, `cfgValue` equals the `RESET_VAL` parameter, `statusPulse` is 0 and `rxBit` is 0.
- R2: In normal mode (`cfgValue[21]`=0), a write of N >= 24 bits replaces `cfgValue[23:0]` with the last 24 bits received, leaving bits 47..24 unchanged. This holds for any N, including N beyond 49, where the bit counter saturates.
- R3: In normal mode, a write of fewer than 24 bits leaves `cfgValue` unchanged.
- R4: In extended mode (`cfgValue[21]`=1), a write of exactly 24 bits replaces only bits 23..0. A write of exactly 48 bits replaces all 48 bits, with the first received bit landing in bit 47.
- R5: In extended mode, a write of any other count (0..23, 25..47, above 48) leaves `cfgValue` unchanged.
- R6: A write that is dropped after at least 16 bits makes `statusPulse` high for exactly one system clock, in the cycle after the falling edge of `regSel` is sampled. A write that is committed, or dropped with fewer than 16 bits, produces no pulse.
- R7: In normal mode, a read presents `cfgValue[23:0]` MSB first on `rxBit`, whatever bit 18 holds. The first bit is valid before the first interface clock rise, and each rise advances one bit. After 24 bits, `rxBit` is 0.
- R8: In extended mode, a read presents all 48 bits MSB first when `cfgValue[18]`=1. It presents only bits 23..0 when `cfgValue[18]`=0. After the last bit, `rxBit` is 0.
- R9: `cfgValue` never changes while `regSel` is high, and a read session never changes it.
- R10: `rxBit` is 0 whenever no read session is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Interface clock from the host, synchronous to `clk` and slower than it |
| regSel | input | 1 | Register session select, active high; its fall commits a write |
| rdNotWr | input | 1 | Session direction: 1 read, 0 write; held for the whole session |
| txBit | input | 1 | Serial write data, MSB first |
| rxBit | output | 1 | Serial read data, MSB first; 0 when idle |
| cfgValue | output | FULL_W | Current configuration register contents |
| statusPulse | output | 1 | One-cycle pulse for a dropped write of at least 16 bits |

## Verification
The hardest conditions to reach are the ones that depend on a mode the host must first program through the same port. These are extended-mode length checks, the 48-bit read, and protection of the upper half. The stimulus therefore sweeps every write length from 0 to 52 in normal mode first. It then writes a 24-bit frame with bit 21 set to switch modes, and repeats the full sweep while forcing bit 21 in each frame that will commit, so the mode is never lost mid-sweep. Lengths 49 to 52 drive the bit counter into saturation. Reads are taken in each mode and with both values of bit 18, and a read is compared over two bits beyond its length to check the trailing zeros.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

  typedef struct packed {
    logic clrCount;
    logic shiftIn;
    logic loadRead;
    logic shiftOut;
    logic commitLow;
    logic commitFull;
  } cfgStrobes_t;

endpackage

// File: rtl/cfg_serial_ctrl.sv
module cfg_serial_ctrl
  import cfg_serial_pkg::*;
#(
  parameter int BASE_W     = 24,
  parameter int FULL_W     = 48,
  parameter int MIN_REPORT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serClk,
  input  logic        regSel,
  input  logic        rdNotWr,
  input  logic        extMode,
  input  logic        rdMsb,
  output cfgStrobes_t strobes,
  output logic        rxBit,
  output logic        statusPulse
);

  localparam int CNT_MAX = FULL_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             serClkQ;
  logic             regSelQ;
  logic             wrActive;
  logic             rdActive;
  logic [CNT_W-1:0] bitCount;

  logic clkRise, selRise, selFall, wrFall;
  logic isBase, isFull, atLeastBase, enoughToReport;
  logic dropWrite;

  always_comb begin
    clkRise        = serClk & ~serClkQ;
    selRise        = regSel & ~regSelQ;
    selFall        = ~regSel & regSelQ;
    wrFall         = selFall & wrActive;

    isBase         = (bitCount == CNT_W'(BASE_W));
    isFull         = (bitCount == CNT_W'(FULL_W));
    atLeastBase    = (bitCount >= CNT_W'(BASE_W));
    enoughToReport = (bitCount >= CNT_W'(MIN_REPORT));

    strobes.clrCount   = selRise;
    strobes.shiftIn    = wrActive & regSel & clkRise;
    strobes.loadRead   = selRise & rdNotWr;
    strobes.shiftOut   = rdActive & regSel & clkRise;
    strobes.commitFull = wrFall & extMode & isFull;
    strobes.commitLow  = wrFall & (extMode ? isBase : atLeastBase);

    dropWrite = wrFall & ~(strobes.commitLow | strobes.commitFull);
    rxBit     = rdActive & rdMsb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serClkQ     <= 1'b0;
      regSelQ     <= 1'b0;
      wrActive    <= 1'b0;
      rdActive    <= 1'b0;
      bitCount    <= '0;
      statusPulse <= 1'b0;
    end else begin
      serClkQ     <= serClk;
      regSelQ     <= regSel;
      statusPulse <= dropWrite & enoughToReport;

      if (selRise) begin
        wrActive <= ~rdNotWr;
        rdActive <= rdNotWr;
      end else if (selFall) begin
        wrActive <= 1'b0;
        rdActive <= 1'b0;
      end

      if (strobes.clrCount) begin
        bitCount <= '0;
      end else if (strobes.shiftIn && bitCount < CNT_W'(CNT_MAX)) begin
        bitCount <= bitCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfg_serial_dp.sv
module cfg_serial_dp
  import cfg_serial_pkg::*;
#(
  parameter int                BASE_W    = 24,
  parameter int                FULL_W    = 48,
  parameter int                EXT_BIT   = 21,
  parameter int                LONG_BIT  = 18,
  parameter logic [FULL_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobes_t       strobes,
  input  logic              txBit,
  output logic [FULL_W-1:0] cfgValue,
  output logic              extMode,
  output logic              rdMsb
);

  localparam int PAD_W = FULL_W - BASE_W;

  logic [FULL_W-1:0] wrShift;
  logic [FULL_W-1:0] rdShift;
  logic [FULL_W-1:0] rdImage;
  logic              longRead;

  always_comb begin
    extMode  = cfgValue[EXT_BIT];
    longRead = cfgValue[EXT_BIT] & cfgValue[LONG_BIT];
    rdImage  = longRead ? cfgValue : {cfgValue[BASE_W-1:0], {PAD_W{1'b0}}};
    rdMsb    = rdShift[FULL_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrShift <= '0;
    end else if (strobes.clrCount) begin
      wrShift <= '0;
    end else if (strobes.shiftIn) begin
      wrShift <= {wrShift[FULL_W-2:0], txBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdShift <= '0;
    end else if (strobes.loadRead) begin
      rdShift <= rdImage;
    end else if (strobes.shiftOut) begin
      rdShift <= {rdShift[FULL_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgValue <= RESET_VAL;
    end else if (strobes.commitFull) begin
      cfgValue <= wrShift;
    end else if (strobes.commitLow) begin
      cfgValue[BASE_W-1:0] <= wrShift[BASE_W-1:0];
    end
  end

endmodule

// File: rtl/cfg_serial_access.sv
module cfg_serial_access
  import cfg_serial_pkg::*;
#(
  parameter int                BASE_W     = 24,
  parameter int                FULL_W     = 48,
  parameter int                MIN_REPORT = 16,
  parameter int                EXT_BIT    = 21,
  parameter int                LONG_BIT   = 18,
  parameter logic [FULL_W-1:0] RESET_VAL  = 48'h0000_0011_2233
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              regSel,
  input  logic              rdNotWr,
  input  logic              txBit,
  output logic              rxBit,
  output logic [FULL_W-1:0] cfgValue,
  output logic              statusPulse
);

  cfgStrobes_t strobes;
  logic        extMode;
  logic        rdMsb;

  cfg_serial_ctrl #(
    .BASE_W    (BASE_W),
    .FULL_W    (FULL_W),
    .MIN_REPORT(MIN_REPORT)
  ) ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .serClk     (serClk),
    .regSel     (regSel),
    .rdNotWr    (rdNotWr),
    .extMode    (extMode),
    .rdMsb      (rdMsb),
    .strobes    (strobes),
    .rxBit      (rxBit),
    .statusPulse(statusPulse)
  );

  cfg_serial_dp #(
    .BASE_W   (BASE_W),
    .FULL_W   (FULL_W),
    .EXT_BIT  (EXT_BIT),
    .LONG_BIT (LONG_BIT),
    .RESET_VAL(RESET_VAL)
  ) dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .txBit   (txBit),
    .cfgValue(cfgValue),
    .extMode (extMode),
    .rdMsb   (rdMsb)
  );

endmodule

// File: rtl/cfg_serial_access_chk.sv
module cfg_serial_access_chk #(
  parameter int BASE_W  = 24,
  parameter int FULL_W  = 48,
  parameter int EXT_BIT = 21
) (
  input logic              clk,
  input logic              rstN,
  input logic              regSel,
  input logic              rxBit,
  input logic [FULL_W-1:0] cfgValue,
  input logic              statusPulse
);

  // R9
  commit_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !($past(regSel) && !regSel) |=> $stable(cfgValue));

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusPulse |=> !statusPulse);

  // R6
  pulse_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusPulse |-> $stable(cfgValue));

  // R2
  upper_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValue[EXT_BIT] |=> $stable(cfgValue[FULL_W-1:BASE_W]));

  // R10
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regSel && !$past(regSel)) |-> !rxBit);

endmodule

bind cfg_serial_access cfg_serial_access_chk #(
  .BASE_W (BASE_W),
  .FULL_W (FULL_W),
  .EXT_BIT(EXT_BIT)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .regSel     (regSel),
  .rxBit      (rxBit),
  .cfgValue   (cfgValue),
  .statusPulse(statusPulse)
);

// File: tb/cfg_serial_access_test.sv
`timescale 1ns/1ps
module cfg_serial_access_test;

  localparam logic [47:0] RESET_VAL = 48'h0000_0011_2233;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        regSel = 1'b0;
  logic        rdNotWr = 1'b0;
  logic        txBit = 1'b0;
  logic        rxBit;
  logic [47:0] cfgValue;
  logic        statusPulse;

  logic [47:0] model;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  cfg_serial_access #(.RESET_VAL(RESET_VAL)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .serClk     (serClk),
    .regSel     (regSel),
    .rdNotWr    (rdNotWr),
    .txBit      (txBit),
    .rxBit      (rxBit),
    .cfgValue   (cfgValue),
    .statusPulse(statusPulse)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  function automatic logic [63:0] pattern(input int n);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(n + 7)) ^ (64'(n) << 40);
  endfunction

  task automatic sendBit(input logic b);
    txBit  = b;
    serClk = 1'b1;
    tick(2);
    serClk = 1'b0;
    tick(2);
  endtask

  // One write frame of n bits: data[n-1] is sent first.
  task automatic writeFrame(input int n, input logic [63:0] data, input string req);
    logic [47:0] expCfg;
    logic        expPulse;
    logic        commitLow, commitFull;
    logic        ext;
    ext        = model[21];
    commitFull = ext && (n == 48);
    commitLow  = ext ? (n == 24) : (n >= 24);
    expCfg     = model;
    if (commitFull) expCfg = data[47:0];
    else if (commitLow) expCfg[23:0] = data[23:0];
    expPulse   = !(commitLow || commitFull) && (n >= 16);

    rdNotWr = 1'b0;
    regSel  = 1'b1;
    tick(2);
    for (int i = 0; i < n; i++) sendBit(data[n-1-i]);
    check(cfgValue === model, "R9", $sformatf("held during write n=%0d", n), 64'(cfgValue), 64'(model));
    regSel = 1'b0;
    tick(1);
    check(cfgValue === expCfg, req, $sformatf("value after write n=%0d", n), 64'(cfgValue), 64'(expCfg));
    check(statusPulse === expPulse, "R6", $sformatf("pulse n=%0d", n), 64'(statusPulse), 64'(expPulse));
    tick(1);
    check(statusPulse === 1'b0, "R6", $sformatf("pulse ends n=%0d", n), 64'(statusPulse), 64'h0);
    model = expCfg;
    tick(1);
  endtask

  task automatic readFrame(input string req);
    logic [49:0] got;
    logic [49:0] exp;
    logic        isLong;
    isLong = model[21] && model[18];
    exp    = isLong ? {model, 2'b00} : {model[23:0], 26'b0};
    rdNotWr = 1'b1;
    regSel  = 1'b1;
    tick(2);
    for (int i = 0; i < 50; i++) begin
      got[49-i] = rxBit;
      serClk = 1'b1;
      tick(2);
      serClk = 1'b0;
      tick(2);
    end
    check(got === exp, req, $sformatf("read stream long=%0d", isLong), 64'(got), 64'(exp));
    regSel = 1'b0;
    tick(1);
    check(cfgValue === model, "R9", "unchanged by read", 64'(cfgValue), 64'(model));
    check(statusPulse === 1'b0, "R6", "no pulse on read", 64'(statusPulse), 64'h0);
    tick(1);
    rdNotWr = 1'b0;
    check(rxBit === 1'b0, "R10", "idle after read", 64'(rxBit), 64'h0);
    tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    model = RESET_VAL;
    tick(4);
    rstN = 1'b1;
    tick(1);
    // R1
    check(cfgValue === RESET_VAL, "R1", "reset value", 64'(cfgValue), 64'(RESET_VAL));
    check(statusPulse === 1'b0, "R1", "reset pulse", 64'(statusPulse), 64'h0);
    check(rxBit === 1'b0, "R10", "idle after reset", 64'(rxBit), 64'h0);

    // R7: normal read of reset contents
    readFrame("R7");

    // R2 R3 R6: normal-mode sweep over every length 0..52
    for (int n = 0; n <= 52; n++) begin
      d = pattern(n);
      d[21] = 1'b0;
      writeFrame(n, d, (n >= 24) ? "R2" : "R3");
    end

    // R7: bit 18 set but normal mode still reads 24 bits
    d = 64'h0000_0000_00C5_A5E7;
    d[21] = 1'b0;
    d[18] = 1'b1;
    writeFrame(24, d, "R2");
    readFrame("R7");

    // Enter extended mode with bit 18 clear, R8 short read
    d = 64'h0000_0000_003A_6C19;
    d[21] = 1'b1;
    d[18] = 1'b0;
    writeFrame(24, d, "R2");
    readFrame("R8");

    // R4 R5 R6: extended-mode sweep over every length 0..52
    for (int n = 0; n <= 52; n++) begin
      d = pattern(n + 100);
      if (n == 24) d[21] = 1'b1;
      if (n == 48) d[45:21] = {3'b101, 21'h1A2B3C, 1'b1};
      writeFrame(n, d, (n == 24 || n == 48) ? "R4" : "R5");
    end

    // R4: full write, then a 24-bit write keeps the upper half
    d = 64'h0000_C3D2_E1F0_5A5A;
    d[21] = 1'b1;
    writeFrame(48, d, "R4");
    d = 64'h0000_0000_0064_1E0F;
    d[21] = 1'b1;
    d[18] = 1'b1;
    writeFrame(24, d, "R4");
    // R8: long read of all 48 bits
    readFrame("R8");

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule